// File: doc/BRIEF.md
# Set-Banked Exact LRU Order Tracker

This block keeps the exact least-recently-used order of the ways of every set in a cache. Each set owns a triangular array of precedence bits, one bit per unordered pair of ways. The bit for a pair records which way of the two was touched more recently. A reference to a way marks it as newer than every other way of its set. The oldest way is the one that is newer than none of the others.

The cache pulses `ref_valid_i` with a set number and a way number whenever a way is touched. Hits and miss fills are both references. Separately, the cache presents a set number on `query_set_i` and reads back the victim way of that set, both as a binary number and as a one-hot vector. The answer is combinational from the stored bits, so a reference made in a cycle is reflected in the answer from the next cycle on. The way count is a parameter and supports 4 and 8 ways. The set count is a power-of-two parameter.

Top module: `lru_matrix_bank`

## Requirements
- R1: After reset, every set reports way 0 as its least recently used way, and its order runs from way 0 (oldest) up to way NUM_WAYS-1 (newest).
- R2: After any sequence of references, the reported victim of a set equals the last entry of a move-to-front list for that set. The list starts in the R1 order, and each reference to the set moves the referenced way to the front.
- R3: With 4 ways, the references 2, 1, 3, 0, 3, 2, 1 to one freshly reset set leave way 0 as that set's victim.
- R4: `lru_onehot_o` always has exactly one bit set, bit position equal to `lru_way_o`.
- R5: When a reference and a query hit the same set in the same cycle, the query returns the victim from before that reference. The effect of the reference appears from the following cycle.
- R6: A reference to one set leaves the reported victim of every other set unchanged, and a cycle without a reference changes no set.
- R7: Referencing the most recently used way of a set again leaves that set's victim unchanged.
- R8: Referencing the current victim of a set makes the second-oldest way of that set the new victim on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | 1 | Reference strobe, one per cycle at most |
| ref_set_i | input | $clog2(NUM_SETS) | Set of the referenced way |
| ref_way_i | input | $clog2(NUM_WAYS) | Referenced way number |
| query_set_i | input | $clog2(NUM_SETS) | Set whose victim is reported |
| lru_way_o | output | $clog2(NUM_WAYS) | Least recently used way of the queried set, binary |
| lru_onehot_o | output | NUM_WAYS | Least recently used way of the queried set, one-hot |

## Verification
A reference update and a victim query can fall in the same cycle on the same set. The bench provokes this in directed steps and in roughly half of its random steps, by steering the query set onto the reference set. In each such cycle the output is sampled after the inputs settle and before the clock edge, and it is judged against the move-to-front model as it stood before the reference. The next cycle is then judged against the model after the reference, so an update that leaks through early, or one that is lost, shows up as a mismatch.

// File: rtl/lru_pkg.sv
package lru_pkg;
  // Flat position of pair (i, j), i < j, in a triangular bit array of n ways
  function automatic int tri_idx(int i, int j, int n);
    return i * n - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction
endpackage

// File: rtl/lru_tri_update.sv
module lru_tri_update #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int PAIRS = NUM_WAYS * (NUM_WAYS - 1) / 2
) (
  input  logic [PAIRS-1:0] cur_i,
  input  logic             en_i,
  input  logic [WAY_W-1:0] way_i,
  output logic [PAIRS-1:0] nxt_o
);
  // Bit (i,j) set means way i newer than way j; row of the ref'd way set, column cleared
  for (genvar gi = 0; gi < NUM_WAYS - 1; gi++) begin : g_row
    for (genvar gj = gi + 1; gj < NUM_WAYS; gj++) begin : g_col
      localparam int IDX = lru_pkg::tri_idx(gi, gj, NUM_WAYS);
      logic hit_row, hit_col;
      assign hit_row = en_i && (way_i == WAY_W'(gi));
      assign hit_col = en_i && (way_i == WAY_W'(gj));
      assign nxt_o[IDX] = hit_row ? 1'b1 : (hit_col ? 1'b0 : cur_i[IDX]);
    end
  end
endmodule

// File: rtl/lru_tri_detect.sv
module lru_tri_detect #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int PAIRS = NUM_WAYS * (NUM_WAYS - 1) / 2
) (
  input  logic [PAIRS-1:0]    bits_i,
  output logic [NUM_WAYS-1:0] onehot_o,
  output logic [WAY_W-1:0]    way_o
);
  // Victim: row of zeros; lower-triangle entries read as inverse of mirrored bit
  always_comb begin
    for (int i = 0; i < NUM_WAYS; i++) begin
      onehot_o[i] = 1'b1;
      for (int j = 0; j < NUM_WAYS; j++) begin
        if (j > i) begin
          if (bits_i[lru_pkg::tri_idx(i, j, NUM_WAYS)]) onehot_o[i] = 1'b0;
        end else if (j < i) begin
          if (!bits_i[lru_pkg::tri_idx(j, i, NUM_WAYS)]) onehot_o[i] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    way_o = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (onehot_o[i]) way_o = way_o | WAY_W'(i);
    end
  end
endmodule

// File: rtl/lru_matrix_bank.sv
module lru_matrix_bank #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int PAIRS = NUM_WAYS * (NUM_WAYS - 1) / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ref_valid_i,
  input  logic [SET_W-1:0]    ref_set_i,
  input  logic [WAY_W-1:0]    ref_way_i,
  input  logic [SET_W-1:0]    query_set_i,
  output logic [WAY_W-1:0]    lru_way_o,
  output logic [NUM_WAYS-1:0] lru_onehot_o
);
  logic [PAIRS-1:0] bank_q [NUM_SETS];

  for (genvar gs = 0; gs < NUM_SETS; gs++) begin : g_set
    logic [PAIRS-1:0] nxt;
    logic             sel;
    assign sel = ref_valid_i && (ref_set_i == SET_W'(gs));

    lru_tri_update #(.NUM_WAYS(NUM_WAYS)) upd_i (
      .cur_i (bank_q[gs]),
      .en_i  (sel),
      .way_i (ref_way_i),
      .nxt_o (nxt)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bank_q[gs] <= '0;
      else if (sel) bank_q[gs] <= nxt;
    end
  end

  // One detector behind the set mux; reads state before any same-cycle update
  lru_tri_detect #(.NUM_WAYS(NUM_WAYS)) det_i (
    .bits_i   (bank_q[query_set_i]),
    .onehot_o (lru_onehot_o),
    .way_o    (lru_way_o)
  );

  // R4
  victim_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(lru_onehot_o) == 1) && lru_onehot_o[lru_way_o]);

  // R2
  ref_not_victim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_i |=> !((query_set_i == $past(ref_set_i)) && (lru_way_o == $past(ref_way_i))));

  // R6
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_valid_i |=> (query_set_i != $past(query_set_i)) || (lru_way_o == $past(lru_way_o)));

  // R8
  victim_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && (ref_set_i == query_set_i) && (ref_way_i == lru_way_o))
      |=> (query_set_i != $past(query_set_i)) || (lru_way_o != $past(lru_way_o)));
endmodule

// File: tb/lru_matrix_bank_tb_top.sv
`timescale 1ns/1ps
module lru_matrix_bank_tb_top;
  localparam int B = 4;
  localparam int S = 8;
  localparam int WW = $clog2(B);
  localparam int SW = $clog2(S);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_valid = 1'b0;
  logic [SW-1:0] ref_set = '0;
  logic [WW-1:0] ref_way = '0;
  logic [SW-1:0] query_set = '0;
  logic [WW-1:0] lru_way;
  logic [B-1:0]  lru_onehot;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int order [S][B]; // [0] newest, [B-1] oldest

  always #2 clk = ~clk;

  lru_matrix_bank #(.NUM_WAYS(B), .NUM_SETS(S)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .ref_valid_i (ref_valid),
    .ref_set_i (ref_set), .ref_way_i (ref_way), .query_set_i (query_set),
    .lru_way_o (lru_way), .lru_onehot_o (lru_onehot)
  );

  function automatic int model_lru(int s);
    return order[s][B-1];
  endfunction

  task automatic model_ref(int s, int w);
    int pos = 0;
    for (int p = 0; p < B; p++) if (order[s][p] == w) pos = p;
    for (int p = pos; p > 0; p--) order[s][p] = order[s][p-1];
    order[s][0] = w;
  endtask

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive at negedge, sample pre-edge result, then advance model
  task automatic step(bit v, int s, int w, int q, string tag);
    @(negedge clk);
    ref_valid = v;
    ref_set = SW'(s);
    ref_way = WW'(w);
    query_set = SW'(q);
    #1;
    check(tag, int'(lru_way), model_lru(q));
    check({tag, "/R4"}, int'(lru_onehot), 1 << model_lru(q));
    if (v) model_ref(s, w);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seq [7] = '{2, 1, 3, 0, 3, 2, 1};
    void'($urandom(32'd20240611));
    for (int s = 0; s < S; s++)
      for (int p = 0; p < B; p++) order[s][p] = B - 1 - p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset order, every set
    for (int s = 0; s < S; s++) begin
      step(1'b0, 0, 0, s, "R1");
      check("R1 literal", int'(lru_way), 0);
    end

    // R3 directed sequence on set 2
    foreach (seq[k]) step(1'b1, 2, seq[k], 2, "R3");
    step(1'b0, 0, 0, 2, "R3");
    check("R3 literal", int'(lru_way), 0);

    // R5 same-cycle ref and query; R8 victim moves on
    step(1'b1, 3, 0, 3, "R5");
    check("R5 pre-update", int'(lru_way), 0);
    step(1'b0, 0, 0, 3, "R8");
    check("R8 literal", int'(lru_way), 1);

    // R7 re-reference of newest way
    step(1'b1, 3, 0, 3, "R7");
    step(1'b1, 3, 0, 3, "R7");
    step(1'b0, 0, 0, 3, "R7");
    check("R7 literal", int'(lru_way), 1);

    // R6 traffic on set 5 leaves set 4 and set 6 untouched
    for (int k = 0; k < 6; k++) step(1'b1, 5, k % B, 4, "R6");
    step(1'b0, 0, 0, 4, "R6");
    check("R6 literal", int'(lru_way), 0);
    step(1'b0, 0, 0, 6, "R6");
    check("R6 literal", int'(lru_way), 0);

    // R2 random mix, query often steered onto the reference set
    for (int k = 0; k < 3000; k++) begin
      bit v = ($urandom % 10) < 7;
      int s = $urandom % S;
      int w = $urandom % B;
      int q = ($urandom % 2) ? s : ($urandom % S);
      if (($urandom % 8) == 0) w = model_lru(s);
      step(v, s, w, q, "R2");
    end
    for (int s = 0; s < S; s++) step(1'b0, 0, 0, s, "R2");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule